// File: doc/BRIEF.md
# Framing path error counter

This block counts path-level errors on a received T1 stream. It does not look at the line itself. A framer upstream supplies one-cycle error strobes: a CRC-6 check failure strobe, a terminal framing (Ft) bit error strobe and a signalling framing (Fs) bit error strobe. Two mode inputs choose which strobes count. In extended-superframe mode only CRC-6 failures are counted. In superframe (D4) mode Ft errors are counted. Fs errors are added only when the Fs-report control is set.

A 12-bit accumulator gathers the selected events. It saturates at its maximum and stops counting while the receive loss-of-synchronization flag is high. A one-second pulse copies the accumulator into a registered snapshot and starts a new interval. Between pulses, the snapshot therefore always holds the error count of the previous second. Software can read the snapshot at leisure during the following second.

Top module: `frame_path_errcnt`

## Requirements
- R1: A synchronous active-high reset clears both the snapshot and the accumulator to zero.
- R2: With `esf_mode`=1, each cycle with `crc_err`=1 adds one to the count, and `ft_err` and `fs_err` have no effect.
- R3: With `esf_mode`=0, each cycle with `ft_err`=1 adds one to the count, and `crc_err` has no effect.
- R4: With `esf_mode`=0, `fs_err` adds one per cycle only while `fs_report`=1. It is ignored while `fs_report`=0.
- R5: In D4 mode with `fs_report`=1, a cycle in which both `ft_err` and `fs_err` are high adds two to the count.
- R6: While `sync_lost`=1 no strobe changes the count.
- R7: The snapshot changes only on a clock edge where `sec_tick`=1. On that edge it takes the count accumulated since the previous tick, and it is visible from the following cycle.
- R8: On a `sec_tick` edge the accumulator restarts from zero. Events qualified in that same cycle count toward the new interval.
- R9: The count saturates at 4095 and never wraps, including when an increment of two would pass the maximum.
- R10: Changing `esf_mode` or `fs_report` takes effect from the next clock edge and does not clear the accumulated count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_err | input | 1 | CRC-6 code-word failure strobe |
| ft_err | input | 1 | Ft framing-bit error strobe |
| fs_err | input | 1 | Fs framing-bit error strobe |
| esf_mode | input | 1 | 1 = extended superframe, 0 = D4 superframe |
| fs_report | input | 1 | In D4 mode, also count Fs errors |
| sync_lost | input | 1 | Receive loss of synchronization; freezes counting |
| sec_tick | input | 1 | One-second boundary pulse |
| snapshot | output | 12 | Error count of the previous one-second interval |

## Verification
In each framing mode, the bench drives all three strobe kinds together. A snapshot equal to the count of the selected kind alone shows that the unselected strobes are rejected. D4 runs mix lone Ft strobes, lone Fs strobes and coincident Ft+Fs strobes with Fs reporting both on and off. This separates a counter that adds two on coincident strobes from one that adds only one. Bursts under loss of synchronization, an error in the same cycle as the tick, and a mode switch in mid-interval each target one ordering rule. A run that ends at 4094 before a double increment, and a run well past the maximum, show saturation rather than wrap.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int CNT_W_DEF = 12;
  localparam int INC_W     = 2;
  typedef logic [INC_W-1:0] inc_t;
endpackage

// File: rtl/fpe_event_sel.sv
module fpe_event_sel
  import fpe_pkg::*;
(
  input  logic crc_err,
  input  logic ft_err,
  input  logic fs_err,
  input  logic esf_mode,
  input  logic fs_report,
  input  logic sync_lost,
  output inc_t inc
);
  logic ft_q, fs_q;

  always_comb begin
    ft_q = ft_err;
    fs_q = fs_err & fs_report;
    if (sync_lost)
      inc = '0;
    else if (esf_mode)
      inc = inc_t'(crc_err);
    else
      inc = inc_t'(ft_q) + inc_t'(fs_q);
  end
endmodule

// File: rtl/fpe_sat_accum.sv
module fpe_sat_accum
  import fpe_pkg::*;
#(
  parameter int W = CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  inc_t         inc,
  output logic [W-1:0] acc
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = restart ? '0 : acc;
    sum  = {1'b0, base} + (W+1)'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (sum[W] || sum[W-1:0] == MAX_V)
      acc <= MAX_V;
    else
      acc <= sum[W-1:0];
  end
endmodule

// File: rtl/fpe_snapshot.sv
module fpe_snapshot #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= d;
  end
endmodule

// File: rtl/frame_path_errcnt.sv
module frame_path_errcnt
  import fpe_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc_err,
  input  logic             ft_err,
  input  logic             fs_err,
  input  logic             esf_mode,
  input  logic             fs_report,
  input  logic             sync_lost,
  input  logic             sec_tick,
  output logic [CNT_W-1:0] snapshot
);
  inc_t             inc;
  logic [CNT_W-1:0] acc_q;

  fpe_event_sel u_sel (
    .crc_err   (crc_err),
    .ft_err    (ft_err),
    .fs_err    (fs_err),
    .esf_mode  (esf_mode),
    .fs_report (fs_report),
    .sync_lost (sync_lost),
    .inc       (inc)
  );

  fpe_sat_accum #(.W(CNT_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (sec_tick),
    .inc     (inc),
    .acc     (acc_q)
  );

  fpe_snapshot #(.W(CNT_W)) u_snap (
    .clk  (clk),
    .rst  (rst),
    .load (sec_tick),
    .d    (acc_q),
    .q    (snapshot)
  );
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             crc_err,
  input logic             esf_mode,
  input logic             sync_lost,
  input logic             sec_tick,
  input logic [CNT_W-1:0] acc,
  input logic [CNT_W-1:0] snapshot
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  a_r7_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> $stable(snapshot));

  a_r7_snap_load: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> snapshot == $past(acc));

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && !sec_tick) |=> $stable(acc));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (acc == MAXV && !sec_tick) |=> acc == MAXV);

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> acc <= CNT_W'(2));

  a_r2_esf_only_crc: assert property (@(posedge clk) disable iff (rst)
    (esf_mode && !crc_err && !sec_tick) |=> $stable(acc));
endmodule

bind frame_path_errcnt fpe_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .crc_err   (crc_err),
  .esf_mode  (esf_mode),
  .sync_lost (sync_lost),
  .sec_tick  (sec_tick),
  .acc       (acc_q),
  .snapshot  (snapshot)
);

// File: tb/frame_path_errcnt_test.sv
module frame_path_errcnt_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crc_err = 0, ft_err = 0, fs_err = 0;
  logic esf_mode = 0, fs_report = 0, sync_lost = 0, sec_tick = 0;
  logic [11:0] snapshot;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frame_path_errcnt uut (
    .clk(clk), .rst(rst), .crc_err(crc_err), .ft_err(ft_err), .fs_err(fs_err),
    .esf_mode(esf_mode), .fs_report(fs_report), .sync_lost(sync_lost),
    .sec_tick(sec_tick), .snapshot(snapshot)
  );

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (snapshot !== exp) begin
      errors++;
      $display("FAIL %s: snapshot=%0d expected=%0d", req, snapshot, exp);
    end
  endtask

  task automatic strobe(input logic c, input logic t, input logic s, input int n);
    for (int i = 0; i < n; i++) begin
      crc_err = c; ft_err = t; fs_err = s;
      @(negedge clk);
    end
    crc_err = 0; ft_err = 0; fs_err = 0;
  endtask

  task automatic tick();
    sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
  endtask

  task automatic t_reset();
    check("R1", 12'd0);
    tick();
    check("R1", 12'd0);
  endtask

  task automatic t_esf();
    esf_mode = 1; fs_report = 1; tick();
    strobe(1, 0, 0, 5);
    strobe(0, 1, 0, 3);
    strobe(0, 0, 1, 2);
    strobe(0, 1, 1, 2);
    tick();
    check("R2", 12'd5);
  endtask

  task automatic t_d4();
    esf_mode = 0; fs_report = 0; tick();
    strobe(0, 1, 0, 4);
    strobe(1, 0, 0, 3);
    strobe(0, 0, 1, 3);
    tick();
    check("R3", 12'd4);
    strobe(0, 0, 1, 6);
    tick();
    check("R4", 12'd0);
  endtask

  task automatic t_fs_pairs();
    esf_mode = 0; fs_report = 1; tick();
    strobe(0, 1, 0, 2);
    strobe(0, 0, 1, 3);
    tick();
    check("R4", 12'd5);
    strobe(0, 1, 1, 2);
    tick();
    check("R5", 12'd4);
  endtask

  task automatic t_sync();
    esf_mode = 0; fs_report = 1; tick();
    sync_lost = 1;
    strobe(0, 1, 1, 6);
    sync_lost = 0;
    strobe(0, 1, 0, 2);
    tick();
    check("R6", 12'd2);
  endtask

  task automatic t_hold();
    esf_mode = 0; fs_report = 0; tick();
    strobe(0, 1, 0, 7);
    tick();
    check("R7", 12'd7);
    strobe(0, 1, 0, 3);
    check("R7", 12'd7);
    tick();
    check("R7", 12'd3);
    tick();
    check("R7", 12'd0);
  endtask

  task automatic t_tick_event();
    esf_mode = 0; fs_report = 0; tick();
    strobe(0, 1, 0, 2);
    ft_err = 1; sec_tick = 1;
    @(negedge clk);
    ft_err = 0; sec_tick = 0;
    check("R8", 12'd2);
    tick();
    check("R8", 12'd1);
  endtask

  task automatic t_mode();
    esf_mode = 0; fs_report = 0; tick();
    strobe(0, 1, 0, 3);
    esf_mode = 1;
    strobe(1, 0, 0, 2);
    fs_report = 1; esf_mode = 0;
    strobe(0, 0, 1, 1);
    tick();
    check("R10", 12'd6);
  endtask

  task automatic t_sat();
    esf_mode = 0; fs_report = 1; tick();
    strobe(0, 1, 0, 4094);
    strobe(0, 1, 1, 1);
    tick();
    check("R9", 12'd4095);
    strobe(0, 1, 1, 2100);
    tick();
    check("R9", 12'd4095);
    tick();
    check("R9", 12'd0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_esf();
    t_d4();
    t_fs_pairs();
    t_sync();
    t_hold();
    t_tick_event();
    t_mode();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule